// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds one 64-bit control register that places the memory-mapped PCIe configuration window in the physical address space. Firmware programs the register through a 32-bit configuration write port. Each write carries a half select and four byte enables. The block decodes the register into four window outputs: an enable, a base address, a window size and a reserved-encoding error flag.

On every cycle the block also compares an incoming 64-bit physical address against the decoded window. It returns a hit flag and the byte offset of the address inside the window, with no register on that path. The window follows the register contents, so it is recomputed after every write that touches the register and again when reset is applied.

Top module: `cfg_window_decoder`

## Requirements
- R1: While reset is held, and until the first write, the register holds RESET_VAL (default 0x0000_0000_B000_0000, a 256 MiB window that is disabled). Directly after reset: enable = 0, size = 2^LOG2_MAX, error = 0, base = RESET_VAL masked for a maximum-size window, hit = 0.
- R2: Register bit 0 is the window enable. While it is 0, no address produces a hit.
- R3: The length code in register bits 2:1 selects the size. Code 00 gives 2^LOG2_MAX (256 MiB by default), code 01 gives half that, and code 10 gives a quarter.
- R4: Length code 11 is reserved. It raises the error output, reports a size of 0 and suppresses every hit, whatever the enable bit is.
- R5: The base is the register ANDed with a mask. The mask always keeps bits BASE_HI down to LOG2_MAX and clears every bit above BASE_HI. Bit LOG2_MAX-1 (upper alignment bit) is kept only for code 01. Bit LOG2_MAX-2 (lower alignment bit) is kept for codes 01 and 10. All bits below LOG2_MAX-2 are always cleared.
- R6: The hit output is combinational in the probe address. It is 1 exactly when the window is enabled, the length code is not reserved, and base <= address < base + size. The compare uses all 64 address bits.
- R7: The offset output equals address - base while hit is 1, and 0 otherwise.
- R8: A write with the half select at 0 updates register bytes 0..3, and with the half select at 1 it updates bytes 4..7. Only the bytes whose byte enable is set change.
- R9: A write changes the window outputs from the clock edge that accepts it. Without a write, enable and base hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration port |
| cfgWrHi | input | 1 | Half select: 0 = low 32 bits, 1 = high 32 bits |
| cfgWrBe | input | 4 | Byte enables inside the selected half |
| cfgWrData | input | 32 | Write data |
| probeAddr | input | ADDR_W | Physical address to test |
| winEnable | output | 1 | Decoded enable bit |
| winBase | output | ADDR_W | Masked window base |
| winSize | output | ADDR_W | Window size in bytes, 0 when reserved |
| winErr | output | 1 | Reserved length code programmed |
| winHit | output | 1 | Probe address is inside the enabled window |
| winOffset | output | ADDR_W | Probe address minus base on a hit, else 0 |

## Verification
The bench builds the block with LOG2_MAX = 6, BASE_HI = 9 and RESET_VAL = 0x200. This shrinks the window sizes to 64, 32 and 16 bytes and the base field to bits 9..4. At that size the bench can walk every value of the base field, every length code and both enable states. For each of these settings it sweeps every probe address from 0 to 1100. That covers both window edges, the overlap of bit 4 and bit 5 with the window span under code 01, and the dropped bit 5 under code 10. Directed writes with partial byte enables and writes to the high half cover the byte-write rules and the clearing of bits above BASE_HI.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int REG_BYTES  = 8;
  localparam int HALF_BYTES = 4;

  typedef enum logic [1:0] {
    LEN_FULL    = 2'b00,
    LEN_HALF    = 2'b01,
    LEN_QUARTER = 2'b10,
    LEN_RSVD    = 2'b11
  } lenCode_e;

  typedef struct packed {
    logic [REG_BYTES-1:0] byteWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl
  import cfg_window_pkg::*;
(
  input  logic                  cfgWrEn,
  input  logic                  cfgWrHi,
  input  logic [HALF_BYTES-1:0] cfgWrBe,
  output ctrlStrobe_t           strobe
);
  always_comb begin
    strobe.byteWr = '0;
    if (cfgWrEn) begin
      if (cfgWrHi) strobe.byteWr = {cfgWrBe, {HALF_BYTES{1'b0}}};
      else         strobe.byteWr = {{HALF_BYTES{1'b0}}, cfgWrBe};
    end
  end
endmodule

// File: rtl/cfg_window_datapath.sv
module cfg_window_datapath
  import cfg_window_pkg::*;
#(
  parameter int              ADDR_W    = 64,
  parameter int              LOG2_MAX  = 28,
  parameter int              BASE_HI   = 38,
  parameter logic [63:0]     RESET_VAL = 64'h0000_0000_B000_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              winEnable,
  output logic [ADDR_W-1:0] winBase,
  output logic [ADDR_W-1:0] winSize,
  output logic              winErr,
  output logic              winHit,
  output logic [ADDR_W-1:0] winOffset
);
  localparam logic [ADDR_W-1:0] ONE        = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ALL_ONES   = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] UPPER_MASK =
    (ALL_ONES >> (ADDR_W-1-BASE_HI)) & (ALL_ONES << LOG2_MAX);
  localparam logic [ADDR_W-1:0] HI_ALIGN   = ONE << (LOG2_MAX-1);
  localparam logic [ADDR_W-1:0] LO_ALIGN   = ONE << (LOG2_MAX-2);

  logic [REG_BYTES*8-1:0] ctlReg;
  lenCode_e               lenCode;
  logic [ADDR_W-1:0]      baseMask;
  logic [ADDR_W:0]        endAddr;
  logic                   inRange;

  // Byte-granular register; each byte takes its lane of the 32-bit data bus.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= RESET_VAL;
    end else begin
      for (int i = 0; i < REG_BYTES; i++) begin
        if (strobe.byteWr[i]) ctlReg[8*i +: 8] <= wrData[8*(i%HALF_BYTES) +: 8];
      end
    end
  end

  assign lenCode = lenCode_e'(ctlReg[2:1]);

  always_comb begin
    baseMask = UPPER_MASK;
    winSize  = '0;
    winErr   = 1'b0;
    unique case (lenCode)
      LEN_FULL:    winSize = ONE << LOG2_MAX;
      LEN_HALF: begin
        winSize  = ONE << (LOG2_MAX-1);
        baseMask = UPPER_MASK | HI_ALIGN | LO_ALIGN;
      end
      LEN_QUARTER: begin
        winSize  = ONE << (LOG2_MAX-2);
        baseMask = UPPER_MASK | LO_ALIGN;
      end
      LEN_RSVD:    winErr = 1'b1;
    endcase
  end

  assign winEnable = ctlReg[0];
  assign winBase   = ctlReg[ADDR_W-1:0] & baseMask;
  assign endAddr   = {1'b0, winBase} + {1'b0, winSize};
  assign inRange   = (probeAddr >= winBase) && ({1'b0, probeAddr} < endAddr);
  assign winHit    = winEnable && !winErr && inRange;
  assign winOffset = winHit ? (probeAddr - winBase) : '0;
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfg_window_pkg::*;
#(
  parameter int          ADDR_W    = 64,
  parameter int          LOG2_MAX  = 28,
  parameter int          BASE_HI   = 38,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWrHi,
  input  logic [3:0]        cfgWrBe,
  input  logic [31:0]       cfgWrData,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              winEnable,
  output logic [ADDR_W-1:0] winBase,
  output logic [ADDR_W-1:0] winSize,
  output logic              winErr,
  output logic              winHit,
  output logic [ADDR_W-1:0] winOffset
);
  ctrlStrobe_t strobe;

  cfg_window_ctrl u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgWrHi (cfgWrHi),
    .cfgWrBe (cfgWrBe),
    .strobe  (strobe)
  );

  cfg_window_datapath #(
    .ADDR_W    (ADDR_W),
    .LOG2_MAX  (LOG2_MAX),
    .BASE_HI   (BASE_HI),
    .RESET_VAL (RESET_VAL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (cfgWrData),
    .probeAddr (probeAddr),
    .winEnable (winEnable),
    .winBase   (winBase),
    .winSize   (winSize),
    .winErr    (winErr),
    .winHit    (winHit),
    .winOffset (winOffset)
  );
endmodule

// File: rtl/cfg_window_checker.sv
module cfg_window_checker #(
  parameter int ADDR_W   = 64,
  parameter int LOG2_MAX = 28
)(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] probeAddr,
  input logic              winEnable,
  input logic [ADDR_W-1:0] winBase,
  input logic [ADDR_W-1:0] winSize,
  input logic              winErr,
  input logic              winHit,
  input logic [ADDR_W-1:0] winOffset
);
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !winEnable |-> !winHit); // R2

  AST_SIZE_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !winErr |-> $countones(winSize) == 1); // R3

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    winErr |-> (!winHit && winSize == '0)); // R4

  AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    winBase[LOG2_MAX-3:0] == '0); // R5

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    winHit |-> (probeAddr >= winBase && ({1'b0, probeAddr} < ({1'b0, winBase} + {1'b0, winSize})))); // R6

  AST_OFFSET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !winHit |-> winOffset == '0); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> ($stable(winBase) && $stable(winEnable))); // R9
endmodule

bind cfg_window_decoder cfg_window_checker #(
  .ADDR_W   (ADDR_W),
  .LOG2_MAX (LOG2_MAX)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .probeAddr (probeAddr),
  .winEnable (winEnable),
  .winBase   (winBase),
  .winSize   (winSize),
  .winErr    (winErr),
  .winHit    (winHit),
  .winOffset (winOffset)
);

// File: tb/cfg_window_decoder_bench.sv
module cfg_window_decoder_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 64;
  localparam int          LOG2_MAX   = 6;
  localparam int          BASE_HI    = 9;
  localparam logic [63:0] RESET_VAL  = 64'h200;
  localparam int          WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgWrHi = 1'b0;
  logic [3:0]        cfgWrBe = '0;
  logic [31:0]       cfgWrData = '0;
  logic [ADDR_W-1:0] probeAddr = '0;
  logic              winEnable, winErr, winHit;
  logic [ADDR_W-1:0] winBase, winSize, winOffset;

  int testsRun = 0;
  int testsFailed = 0;
  logic [63:0] model = RESET_VAL;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_decoder #(
    .ADDR_W(ADDR_W), .LOG2_MAX(LOG2_MAX), .BASE_HI(BASE_HI), .RESET_VAL(RESET_VAL)
  ) u_cfg_window_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrHi(cfgWrHi),
    .cfgWrBe(cfgWrBe), .cfgWrData(cfgWrData), .probeAddr(probeAddr),
    .winEnable(winEnable), .winBase(winBase), .winSize(winSize),
    .winErr(winErr), .winHit(winHit), .winOffset(winOffset)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Model from the requirements: base keeps bits 9..6, bit 5 for code 01, bit 4 for codes 01/10.
  function automatic logic [63:0] expBase(input logic [63:0] v);
    logic [63:0] m = 64'h3C0;
    if (v[2:1] == 2'b01) m = m | 64'h30;
    if (v[2:1] == 2'b10) m = m | 64'h10;
    return v & m;
  endfunction

  function automatic logic [63:0] expSize(input logic [63:0] v);
    case (v[2:1])
      2'b00:   return 64'd64;
      2'b01:   return 64'd32;
      2'b10:   return 64'd16;
      default: return 64'd0;
    endcase
  endfunction

  task automatic cfgWrite(input bit hi, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrHi = hi; cfgWrBe = be; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrBe = '0;
    for (int i = 0; i < 4; i++)
      if (be[i]) model[(hi ? 32 : 0) + 8*i +: 8] = data[8*i +: 8];
  endtask

  task automatic checkDecode(input string req);
    check(winEnable == model[0], req, {63'd0, winEnable}, {63'd0, model[0]});
    check(winBase == expBase(model), req, winBase, expBase(model));
    check(winSize == expSize(model), req, winSize, expSize(model));
    check(winErr == (model[2:1] == 2'b11), req, {63'd0, winErr}, {63'd0, model[2:1] == 2'b11});
  endtask

  task automatic checkProbe(input logic [63:0] a);
    logic [63:0] b = expBase(model);
    logic [63:0] s = expSize(model);
    logic        h = model[0] && (model[2:1] != 2'b11) && a >= b && a < b + s;
    probeAddr = a;
    #1;
    check(winHit == h, "R6 hit", {63'd0, winHit}, {63'd0, h});
    check(winOffset == (h ? a - b : 64'd0), "R7 offset", winOffset, h ? a - b : 64'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkDecode("R1 reset");
    check(winBase == 64'h200, "R1 base", winBase, 64'h200);
    checkProbe(64'h200);
    check(winHit == 1'b0, "R1 no hit", {63'd0, winHit}, 64'd0);

    // R2 R3 R4 R5 R6 R7 R9: full sweep of base field, length code and enable
    for (int b = 0; b < 64; b++) begin
      for (int len = 0; len < 4; len++) begin
        for (int en = 0; en < 2; en++) begin
          cfgWrite(1'b0, 4'hF, 32'((b << 4) | (len << 1) | en));
          checkDecode("R3 R4 R5 R9 decode");
          for (int a = 0; a <= 1100; a++) checkProbe(64'(a));
        end
      end
    end

    // R6: upper address bits take part in the compare
    cfgWrite(1'b0, 4'hF, 32'h201);
    checkProbe(64'h1_0000_0200);
    check(winHit == 1'b0, "R6 high alias", {63'd0, winHit}, 64'd0);
    checkProbe(64'h23F);
    check(winHit == 1'b1 && winOffset == 64'h3F, "R6 last byte", winOffset, 64'h3F);

    // R8: a single byte enable changes only byte 0 (bits 9..8 keep their value)
    cfgWrite(1'b0, 4'hF, 32'h3C1);
    cfgWrite(1'b0, 4'b0001, 32'hFFFF_FF03);
    check(winBase == 64'h300, "R8 byte0 only", winBase, 64'h300);
    checkDecode("R8 partial");

    // R8 R5: high-half write lands above BASE_HI and leaves the base alone
    cfgWrite(1'b1, 4'hF, 32'hFFFF_FFFF);
    check(winBase == 64'h300, "R8 R5 high half", winBase, 64'h300);
    checkDecode("R8 high half");

    // R9: no write, outputs hold
    repeat (4) @(negedge clk);
    check(winBase == 64'h300 && winEnable, "R9 hold", winBase, 64'h300);

    // R2: disabling via byte 0 only
    cfgWrite(1'b0, 4'b0001, 32'h0000_0002);
    checkProbe(64'h300);
    check(winHit == 1'b0, "R2 disabled", {63'd0, winHit}, 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule